// File: doc/BRIEF.md
# USB OTG Session Request VBUS Pulsing Sequencer

This block sits on the link side of a USB OTG port and carries out the VBUS part of a session request. It has no direct access to VBUS. It issues single-register write requests to the transceiver's OTG control register through a simple request/acknowledge port. It follows decoded receive-command events that report session end and the state of the two data lines.

After a start pulse, the sequencer sets the VBUS discharge bit and waits for session end to go from 0 to 1. It then clears the discharge bit. Next it waits until both data lines have been in SE0 for a window computed from the clock rate, raises the VBUS charge bit for a fixed number of cycles, and lowers it again. Every access uses the set-bits and clear-bits addresses, so the other control bits, including the two data-line pull-downs, are left alone. A missing session-end edge ends the attempt with a timeout pulse.

Top module: `otg_srp_seq`

## Requirements
- R1: After reset `busy_o`, `wr_req_o`, `done_o` and `timeout_o` are all 0.
- R2: A `start_i` pulse while idle raises a write request to address 0x0B (set bits) with data 0x08, which is bit 3, VBUS discharge.
- R3: While waiting after the discharge set, a receive event with `rx_sess_end_i`=1 raises a clear request (address 0x0C, data 0x08) one cycle after the event, but only if the last session-end value seen in an event was 0. An event that repeats session-end=1 starts nothing.
- R4: If no session-end rise arrives within TMO_CYC cycles of the discharge-set acknowledge, the clear request (0x0C, 0x08) appears TMO_CYC+1 cycles after that acknowledge. `timeout_o` then pulses for one cycle, one cycle after the clear acknowledge. No charge access follows and the block returns to idle.
- R5: The charge-set request (0x0B, data 0x10, bit 4) is issued only after the discharge clear. It also needs SE0_CYC = CLK_KHZ*SE0_MS cycles of SE0 (line state 2'b00, bit 0 DP, bit 1 DM) counted from the last 2'b00 line event. When this event arrives during the wait, the request appears SE0_CYC+2 cycles after it. If the window has already run out, the request appears 2 cycles after the discharge-clear acknowledge.
- R6: Any line event with a nonzero line state restarts the SE0 count.
- R7: The charge-clear request (0x0C, 0x10) appears CHG_CYC+1 cycles after the charge-set acknowledge.
- R8: `done_o` pulses for one cycle, one cycle after the charge-clear acknowledge, and `busy_o` is then 0.
- R9: `start_i` is ignored while `busy_o` is 1.
- R10: A request holds its address and data until acknowledged. It uses only 0x0B or 0x0C with exactly one data bit set, so the pull-down bits 2 and 1 of a register starting at 0x06 stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one session request |
| wr_req_o | output | 1 | Register write request, held until acknowledged |
| wr_addr_o | output | 8 | Register address of the request |
| wr_data_o | output | 8 | Bit mask of the request |
| wr_ack_i | input | 1 | One-cycle acknowledge from the register access engine |
| rx_vld_i | input | 1 | Decoded receive-command event valid |
| rx_sess_end_i | input | 1 | Session-end indication carried by the event |
| rx_line_i | input | 2 | Line state carried by the event: bit 0 DP, bit 1 DM |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the charge pulse has ended |
| timeout_o | output | 1 | One-cycle pulse when the session-end wait expired |

## Verification
Every outcome is timed from a bench-recorded acknowledge or event cycle. The discharge clear comes 1 cycle after the session-end rise, or TMO_CYC+1 cycles after the discharge-set acknowledge. The charge set comes SE0_CYC+2 cycles after the last SE0 event, or 2 cycles after the discharge-clear acknowledge when the window has already expired. The charge clear comes CHG_CYC+1 cycles after its set acknowledge, and the done or timeout pulse 1 cycle after the final acknowledge. The bench counts cycles on the rising edge, drives inputs and samples outputs on the falling edge, and compares the exact cycle differences against these sums rather than waiting within a range.

// File: rtl/otg_srp_pkg.sv
package otg_srp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SET_DIS,
      ST_WAIT_END,
      ST_CLR_DIS,
      ST_WAIT_SE0,
      ST_SET_CHG,
      ST_CHARGE,
      ST_CLR_CHG
   } srp_state_e;

   localparam logic [7:0] OTG_SET_ADDR = 8'h0B;
   localparam logic [7:0] OTG_CLR_ADDR = 8'h0C;
   localparam int unsigned DIS_BIT     = 3;
   localparam int unsigned CHG_BIT     = 4;
   localparam logic [7:0] DIS_MASK     = 8'(1 << DIS_BIT);
   localparam logic [7:0] CHG_MASK     = 8'(1 << CHG_BIT);

endpackage

// File: rtl/srp_span_cnt.sv
module srp_span_cnt #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic hit
);
   if (LIMIT == 0) begin : g_off
      logic unused_in;
      assign unused_in = ^{clk, rst_n, run};
      assign hit = 1'b0;
   end else begin : g_on
      localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
      logic [W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (!run)
            cnt_q <= '0;
         else if (!hit)
            cnt_q <= cnt_q + 1'b1;
      end

      assign hit = run && (cnt_q == W'(LIMIT - 1));
   end
endmodule

// File: rtl/srp_se0_tracker.sv
module srp_se0_tracker #(
   parameter int unsigned SE0_CYC = 120000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vld,
   input  logic [1:0] line,
   output logic       ready
);
   localparam int unsigned SW = $clog2(SE0_CYC + 1);

   if (SE0_CYC < 1) begin : g_bad_window
      $error("srp_se0_tracker: SE0_CYC must be at least 1");
   end

   logic          se0_q;
   logic [SW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         se0_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (vld)
            se0_q <= (line == 2'b00);
         if (vld && line != 2'b00)
            cnt_q <= '0;
         else if (se0_q && cnt_q != SW'(SE0_CYC))
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ready = se0_q && (cnt_q == SW'(SE0_CYC));
endmodule

// File: rtl/otg_srp_seq.sv
module otg_srp_seq
   import otg_srp_pkg::*;
#(
   parameter int unsigned CLK_KHZ = 60000,
   parameter int unsigned SE0_MS  = 2,
   parameter int unsigned CHG_CYC = 600,
   parameter int unsigned TMO_CYC = 6000000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   output logic       wr_req_o,
   output logic [7:0] wr_addr_o,
   output logic [7:0] wr_data_o,
   input  logic       wr_ack_i,
   input  logic       rx_vld_i,
   input  logic       rx_sess_end_i,
   input  logic [1:0] rx_line_i,
   output logic       busy_o,
   output logic       done_o,
   output logic       timeout_o
);
   localparam int unsigned SE0_CYC = CLK_KHZ * SE0_MS;

   if (CHG_CYC < 1) begin : g_bad_charge
      $error("otg_srp_seq: CHG_CYC must be at least 1");
   end

   srp_state_e st_q, st_d;
   logic       sess_q;
   logic       tmo_q;
   logic       end_rise;
   logic       tmo_hit;
   logic       chg_hit;
   logic       se0_ready;

   // session-end edge seen through events only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sess_q <= 1'b0;
      else if (rx_vld_i)
         sess_q <= rx_sess_end_i;
   end
   assign end_rise = rx_vld_i && rx_sess_end_i && !sess_q;

   srp_span_cnt #(.LIMIT(TMO_CYC)) u_tmo (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st_q == ST_WAIT_END),
      .hit   (tmo_hit)
   );

   srp_span_cnt #(.LIMIT(CHG_CYC)) u_chg (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st_q == ST_CHARGE),
      .hit   (chg_hit)
   );

   srp_se0_tracker #(.SE0_CYC(SE0_CYC)) u_se0 (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (rx_vld_i),
      .line  (rx_line_i),
      .ready (se0_ready)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:     if (start_i)           st_d = ST_SET_DIS;
         ST_SET_DIS:  if (wr_ack_i)          st_d = ST_WAIT_END;
         ST_WAIT_END: if (end_rise || tmo_hit) st_d = ST_CLR_DIS;
         ST_CLR_DIS:  if (wr_ack_i)          st_d = tmo_q ? ST_IDLE : ST_WAIT_SE0;
         ST_WAIT_SE0: if (se0_ready)         st_d = ST_SET_CHG;
         ST_SET_CHG:  if (wr_ack_i)          st_d = ST_CHARGE;
         ST_CHARGE:   if (chg_hit)           st_d = ST_CLR_CHG;
         ST_CLR_CHG:  if (wr_ack_i)          st_d = ST_IDLE;
         default:                            st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         tmo_q     <= 1'b0;
         done_o    <= 1'b0;
         timeout_o <= 1'b0;
      end else begin
         st_q      <= st_d;
         done_o    <= (st_q == ST_CLR_CHG) && wr_ack_i;
         timeout_o <= (st_q == ST_CLR_DIS) && wr_ack_i && tmo_q;
         if (st_q == ST_IDLE)
            tmo_q <= 1'b0;
         else if (st_q == ST_WAIT_END && tmo_hit && !end_rise)
            tmo_q <= 1'b1;
      end
   end

   always_comb begin
      wr_req_o  = 1'b0;
      wr_addr_o = '0;
      wr_data_o = '0;
      unique case (st_q)
         ST_SET_DIS: begin wr_req_o = 1'b1; wr_addr_o = OTG_SET_ADDR; wr_data_o = DIS_MASK; end
         ST_CLR_DIS: begin wr_req_o = 1'b1; wr_addr_o = OTG_CLR_ADDR; wr_data_o = DIS_MASK; end
         ST_SET_CHG: begin wr_req_o = 1'b1; wr_addr_o = OTG_SET_ADDR; wr_data_o = CHG_MASK; end
         ST_CLR_CHG: begin wr_req_o = 1'b1; wr_addr_o = OTG_CLR_ADDR; wr_data_o = CHG_MASK; end
         default: ;
      endcase
   end

   assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/otg_srp_seq_chk.sv
module otg_srp_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_req_o,
   input logic [7:0] wr_addr_o,
   input logic [7:0] wr_data_o,
   input logic       wr_ack_i,
   input logic       busy_o,
   input logic       done_o,
   input logic       timeout_o
);
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

   a_r10_addr_set_clr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> (wr_addr_o == 8'h0B || wr_addr_o == 8'h0C));

   a_r10_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> $countones(wr_data_o) == 1);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r4_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !wr_req_o);
endmodule

bind otg_srp_seq otg_srp_seq_chk u_chk (.*);

// File: tb/otg_srp_seq_tb.sv
module otg_srp_seq_tb;
   localparam int unsigned CLK_KHZ = 10;
   localparam int unsigned SE0_MS  = 2;
   localparam int unsigned SE0_CYC = CLK_KHZ * SE0_MS;
   localparam int unsigned CHG_CYC = 12;
   localparam int unsigned TMO_CYC = 40;
   localparam int          LAT     = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       wr_req_o;
   logic [7:0] wr_addr_o, wr_data_o;
   logic       wr_ack_i = 1'b0;
   logic       rx_vld_i = 1'b0;
   logic       rx_sess_end_i = 1'b0;
   logic [1:0] rx_line_i = 2'b00;
   logic       busy_o, done_o, timeout_o;

   always #5 clk = ~clk;

   otg_srp_seq #(.CLK_KHZ(CLK_KHZ), .SE0_MS(SE0_MS), .CHG_CYC(CHG_CYC), .TMO_CYC(TMO_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
      .rx_vld_i(rx_vld_i), .rx_sess_end_i(rx_sess_end_i), .rx_line_i(rx_line_i),
      .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o));

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   int n_req = 0, n_ack = 0, n_done = 0, n_tmo = 0;
   int t_done = 0, t_tmo = 0, t_ev = 0;
   int log_addr [16];
   int log_data [16];
   int log_treq [16];
   int log_tack [16];
   logic [7:0] otg_reg = 8'h06;
   logic       pd_lost = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // register access engine model
   initial begin
      bit in_xfer = 0;
      int lat = 0;
      forever begin
         @(negedge clk);
         if (done_o) begin n_done++; t_done = cyc; end
         if (timeout_o) begin n_tmo++; t_tmo = cyc; end
         if (wr_ack_i) wr_ack_i = 1'b0;
         else if (wr_req_o) begin
            if (!in_xfer) begin
               in_xfer = 1; lat = 0;
               log_addr[n_req] = wr_addr_o;
               log_data[n_req] = wr_data_o;
               log_treq[n_req] = cyc;
               n_req++;
            end
            if (lat == LAT) begin
               wr_ack_i = 1'b1;
               log_tack[n_req-1] = cyc;
               if (wr_addr_o == 8'h0B) otg_reg = otg_reg | wr_data_o;
               else if (wr_addr_o == 8'h0C) otg_reg = otg_reg & ~wr_data_o;
               else otg_reg = wr_data_o;
               if (otg_reg[2:1] != 2'b11) pd_lost = 1'b1;
               in_xfer = 0;
               n_ack++;
            end else lat++;
         end
      end
   end

   task automatic send_rx(input logic se, input logic [1:0] ls);
      @(negedge clk);
      rx_vld_i = 1'b1; rx_sess_end_i = se; rx_line_i = ls; t_ev = cyc;
      @(negedge clk);
      rx_vld_i = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic wait_req(input int k);
      while (n_req < k) @(negedge clk);
   endtask

   task automatic wait_ack(input int k);
      while (n_ack < k) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int t2;
      repeat (3) @(negedge clk);
      chk(!busy_o && !wr_req_o && !done_o && !timeout_o, "R1 reset outputs",
          {busy_o, wr_req_o, done_o, timeout_o}, 0);
      rst_n = 1'b1;
      send_rx(1'b1, 2'b01);           // session end already 1, DP high

      // ---------- run 1: full sequence ----------
      pulse_start();
      wait_req(1);
      chk(log_addr[0] == 8'h0B && log_data[0] == 8'h08, "R2 discharge set",
          log_addr[0]*256 + log_data[0], 'h0B08);
      wait_ack(1);
      send_rx(1'b1, 2'b01);           // repeated 1, no rise
      pulse_start();                  // R9: busy, must be ignored
      repeat (5) @(negedge clk);
      chk(n_req == 1, "R3 no rise without 0 first", n_req, 1);
      send_rx(1'b0, 2'b01);
      send_rx(1'b1, 2'b01);
      wait_req(2);
      chk(log_addr[1] == 8'h0C && log_data[1] == 8'h08, "R3 discharge clear",
          log_addr[1]*256 + log_data[1], 'h0C08);
      chk(log_treq[1] == t_ev + 1, "R3 clear timing", log_treq[1], t_ev + 1);
      wait_ack(2);
      send_rx(1'b1, 2'b00);
      repeat (9) @(negedge clk);
      send_rx(1'b1, 2'b10);           // DM high restarts window
      repeat (3) @(negedge clk);
      chk(n_req == 2, "R6 no charge before window", n_req, 2);
      send_rx(1'b1, 2'b00);
      t2 = t_ev;
      wait_req(3);
      chk(log_addr[2] == 8'h0B && log_data[2] == 8'h10, "R5 charge set",
          log_addr[2]*256 + log_data[2], 'h0B10);
      chk(log_treq[2] == t2 + SE0_CYC + 2, "R5 R6 charge set timing", log_treq[2], t2 + SE0_CYC + 2);
      wait_ack(3);
      @(negedge clk);
      chk(otg_reg == 8'h16, "R7 charge bit on", otg_reg, 'h16);
      wait_req(4);
      chk(log_addr[3] == 8'h0C && log_data[3] == 8'h10, "R7 charge clear",
          log_addr[3]*256 + log_data[3], 'h0C10);
      chk(log_treq[3] - log_tack[2] == CHG_CYC + 1, "R7 charge width",
          log_treq[3] - log_tack[2], CHG_CYC + 1);
      wait_ack(4);
      @(negedge clk);
      chk(done_o == 1'b1 && t_done == log_tack[3] + 1, "R8 done timing", t_done, log_tack[3] + 1);
      chk(!busy_o, "R8 idle after done", busy_o, 0);
      @(negedge clk);
      chk(!done_o && n_done == 1, "R8 done single", n_done, 1);
      chk(n_req == 4, "R9 start ignored while busy", n_req, 4);
      chk(otg_reg == 8'h06, "R10 register restored", otg_reg, 'h06);

      // ---------- run 2: SE0 window already elapsed ----------
      pulse_start();
      wait_ack(5);
      send_rx(1'b0, 2'b00);
      send_rx(1'b1, 2'b00);
      wait_ack(6);
      wait_req(7);
      chk(log_treq[6] - log_tack[5] == 2, "R5 expired window", log_treq[6] - log_tack[5], 2);
      wait_ack(8);
      repeat (2) @(negedge clk);
      chk(n_done == 2 && !busy_o, "R8 second run done", n_done, 2);

      // ---------- run 3: timeout ----------
      pulse_start();
      wait_ack(9);
      wait_req(10);
      chk(log_addr[9] == 8'h0C && log_data[9] == 8'h08, "R4 timeout clear",
          log_addr[9]*256 + log_data[9], 'h0C08);
      chk(log_treq[9] - log_tack[8] == TMO_CYC + 1, "R4 timeout timing",
          log_treq[9] - log_tack[8], TMO_CYC + 1);
      wait_ack(10);
      @(negedge clk);
      chk(timeout_o == 1'b1 && t_tmo == log_tack[9] + 1, "R4 timeout pulse", t_tmo, log_tack[9] + 1);
      repeat (SE0_CYC + 5) @(negedge clk);
      chk(n_req == 10 && !busy_o, "R4 no charge after timeout", n_req, 10);
      chk(n_tmo == 1 && n_done == 2, "R4 timeout count", n_tmo * 10 + n_done, 12);
      chk(!pd_lost && otg_reg == 8'h06, "R10 pull-downs kept", otg_reg, 'h06);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule